// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath stage that takes two WIDTH-bit operands, a four-bit operation select, a carry input and two serial fill bits, and yields a WIDTH-bit result plus a carry-out. It is meant to sit between the source registers and a destination register, so that reading the operands, operating on them and loading the result all fit in one clock period.

The two upper select bits choose one of four units: arithmetic, bitwise logic, right shift or left shift. A single ripple-carry adder serves every arithmetic operation. The two lower select bits steer its second input among B, the one's complement of B, all zeros and all ones, and the carry input is added at bit 0. The carry input therefore works as a fifth select bit and yields seven distinct arithmetic results, with transfer-of-A appearing twice. The logic unit uses the same two lower bits to pick AND, OR, XOR or the complement of A. The shifts move A by one position, and the vacated end is filled from a dedicated serial input.

The select field is treated as a small fixed decode rather than a state machine, because the block holds no state. Its named codes are: unit ARITH=00, LOGIC=01, SHR=10, SHL=11 in sel_in[3:2]; operand source PASS=00, INV=01, ZERO=10, ONES=11 in sel_in[1:0] for arithmetic; logic op AND=00, OR=01, XOR=10, NOTA=11 in sel_in[1:0] for logic.

Top module: `alsu_core`

## Requirements
- R1: With sel_in = 0000, {cout, f_out} equals A + B + cin as a (WIDTH+1)-bit unsigned sum (add, and add with carry when cin = 1).
- R2: With sel_in = 0001, {cout, f_out} equals A + ~B + cin: subtract with borrow when cin = 0, and A − B modulo 2^WIDTH when cin = 1.
- R3: With sel_in = 0010, {cout, f_out} equals A + cin: f_out = A when cin = 0, and A incremented when cin = 1 (all-ones A wraps to zero with cout = 1).
- R4: With sel_in = 0011, {cout, f_out} equals A + (2^WIDTH − 1) + cin: A decremented when cin = 0 (zero wraps to all ones with cout = 0), and f_out = A with cout = 1 when cin = 1.
- R5: With sel_in[3:2] = 01, f_out is A AND B, A OR B, A XOR B or NOT A for sel_in[1:0] = 00, 01, 10, 11; cin has no effect on f_out.
- R6: With sel_in[3:2] = 10, f_out = {ser_r, A[WIDTH-1:1]}; sel_in[1:0], cin and ser_l have no effect.
- R7: With sel_in[3:2] = 11, f_out = {A[WIDTH-2:0], ser_l}; sel_in[1:0], cin and ser_r have no effect.
- R8: cout is the carry out of bit WIDTH−1 of the adder in arithmetic mode, so a carry generated at bit 0 propagates through every stage, and cout is 0 in the logic and shift units.
- R9: The outputs hold no state: f_out and cout follow an input change without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A, also the shift source |
| b_in | input | WIDTH | Operand B |
| sel_in | input | 4 | [3:2] unit select, [1:0] operand source or logic op |
| cin | input | 1 | Carry into bit 0 of the adder |
| ser_r | input | 1 | Bit entering the MSB on a right shift |
| ser_l | input | 1 | Bit entering the LSB on a left shift |
| f_out | output | WIDTH | Result |
| cout | output | 1 | Adder carry-out, 0 outside arithmetic |

## Verification
The bound checker tests on every input change the algebraic identities of each arithmetic code, the complement and shift layouts, and a zero carry-out outside the adder. These properties are expressed only over the ports. Full carry propagation across all stages, wrap-around at the ends of the range, and the insensitivity of each unit to the inputs it ignores are shown by the bench's directed patterns. In those patterns the ignored inputs are toggled while the selected unit's output is watched. The bench's random sweep covers the remaining codes against its behavioural model, and a check placed between clock edges shows that the result is combinational.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    // Unit chosen by sel_in[3:2]; codes are fixed by the select encoding.
    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_LOGIC = 2'b01,
        UNIT_SHR   = 2'b10,
        UNIT_SHL   = 2'b11
    } unit_e;

    // Second adder input chosen by sel_in[1:0] in arithmetic mode.
    typedef enum logic [1:0] {
        YSRC_PASS = 2'b00,
        YSRC_INV  = 2'b01,
        YSRC_ZERO = 2'b10,
        YSRC_ONES = 2'b11
    } ysrc_e;

    // Bitwise operation chosen by sel_in[1:0] in logic mode.
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

    typedef struct packed {
        unit_e      unit;
        logic [1:0] sub;
    } opsel_t;

endpackage

// File: rtl/alsu_operand_sel.sv
module alsu_operand_sel
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_val,
    input  ysrc_e            src,
    output logic [WIDTH-1:0] y_val
);

    always_comb begin
        unique case (src)
            YSRC_PASS: y_val = b_val;
            YSRC_INV:  y_val = ~b_val;
            YSRC_ZERO: y_val = '0;
            YSRC_ONES: y_val = '1;
            default:   y_val = '0;
        endcase
    end

endmodule

// File: rtl/alsu_ripple_adder.sv
module alsu_ripple_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_val,
    input  logic [WIDTH-1:0] y_val,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out
);

    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] chain;

    assign chain[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic prop;
        logic gen;
        assign prop          = x_val[i] ^ y_val[i];
        assign gen           = x_val[i] & y_val[i];
        assign sum[i]        = prop ^ chain[i];
        assign chain[i+1]    = gen | (prop & chain[i]);
    end

    assign c_out = chain[NCARRY-1];

endmodule

// File: rtl/alsu_logic_unit.sv
module alsu_logic_unit
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    input  lop_e             op,
    output logic [WIDTH-1:0] e_val
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (op)
                LOP_AND:  e_val[i] = a_val[i] & b_val[i];
                LOP_OR:   e_val[i] = a_val[i] | b_val[i];
                LOP_XOR:  e_val[i] = a_val[i] ^ b_val[i];
                LOP_NOTA: e_val[i] = ~a_val[i];
                default:  e_val[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alsu_shifter.sv
module alsu_shifter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic             to_left,
    input  logic             fill_r,
    input  logic             fill_l,
    output logic [WIDTH-1:0] h_val
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
        logic from_above;
        logic from_below;
        if (i == TOP) begin : g_msb
            assign from_above = fill_r;
        end else begin : g_mid_hi
            assign from_above = a_val[i+1];
        end
        if (i == 0) begin : g_lsb
            assign from_below = fill_l;
        end else begin : g_mid_lo
            assign from_below = a_val[i-1];
        end
        assign h_val[i] = to_left ? from_below : from_above;
    end

endmodule

// File: rtl/alsu_core.sv
module alsu_core
    import alsu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [3:0]       sel_in,
    input  logic             cin,
    input  logic             ser_r,
    input  logic             ser_l,
    output logic [WIDTH-1:0] f_out,
    output logic             cout
);

    opsel_t            opsel;
    logic [WIDTH-1:0]  y_path;
    logic [WIDTH-1:0]  d_path;
    logic [WIDTH-1:0]  e_path;
    logic [WIDTH-1:0]  h_path;
    logic              add_carry;

    assign opsel = opsel_t'(sel_in);

    alsu_operand_sel #(.WIDTH(WIDTH)) u_ysel (
        .b_val (b_in),
        .src   (ysrc_e'(opsel.sub)),
        .y_val (y_path)
    );

    alsu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x_val (a_in),
        .y_val (y_path),
        .c_in  (cin),
        .sum   (d_path),
        .c_out (add_carry)
    );

    alsu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_val (a_in),
        .b_val (b_in),
        .op    (lop_e'(opsel.sub)),
        .e_val (e_path)
    );

    alsu_shifter #(.WIDTH(WIDTH)) u_shift (
        .a_val   (a_in),
        .to_left (opsel.unit == UNIT_SHL),
        .fill_r  (ser_r),
        .fill_l  (ser_l),
        .h_val   (h_path)
    );

    always_comb begin
        unique case (opsel.unit)
            UNIT_ARITH: begin
                f_out = d_path;
                cout  = add_carry;
            end
            UNIT_LOGIC: begin
                f_out = e_path;
                cout  = 1'b0;
            end
            UNIT_SHR, UNIT_SHL: begin
                f_out = h_path;
                cout  = 1'b0;
            end
            default: begin
                f_out = '0;
                cout  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alsu_core_chk.sv
module alsu_core_chk #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [3:0]       sel_in,
    input  logic             cin,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] f_out,
    input  logic             cout
);

    localparam int WX = WIDTH + 1;

    logic [WX-1:0] full_res;
    logic [WX-1:0] a_ext;
    logic [WX-1:0] b_ext;
    logic [WX-1:0] c_ext;

    assign full_res = {cout, f_out};
    assign a_ext    = {1'b0, a_in};
    assign b_ext    = {1'b0, b_in};
    assign c_ext    = {{WIDTH{1'b0}}, cin};

    always_comb begin
        if (sel_in == 4'b0000)
            AST_ADD_IDENTITY: assert (full_res - b_ext == a_ext + c_ext) else $error("add identity"); // R1
        if (sel_in == 4'b0001 && cin)
            AST_SUB_RESTORE: assert (f_out + b_in == a_in) else $error("subtract identity"); // R2
        if (sel_in == 4'b0010 && !cin)
            AST_XFER_PLAIN: assert (f_out == a_in && !cout) else $error("transfer"); // R3
        if (sel_in == 4'b0011 && !cin)
            AST_DEC_RESTORE: assert (f_out + 1'b1 == a_in) else $error("decrement"); // R4
        if (sel_in == 4'b0111)
            AST_NOT_COMPL: assert ((f_out ^ a_in) == {WIDTH{1'b1}}) else $error("complement"); // R5
        if (sel_in[3:2] == 2'b10)
            AST_SHR_LAYOUT: assert (f_out[WIDTH-1] == ser_r && f_out[WIDTH-2:0] == a_in[WIDTH-1:1]) else $error("shift right"); // R6
        if (sel_in[3:2] == 2'b11)
            AST_SHL_LAYOUT: assert (f_out[0] == ser_l && f_out[WIDTH-1:1] == a_in[WIDTH-2:0]) else $error("shift left"); // R7
        if (sel_in[3:2] != 2'b00)
            AST_NO_CARRY_OUTSIDE: assert (!cout) else $error("carry outside arithmetic"); // R8
    end

endmodule

bind alsu_core alsu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .a_in   (a_in),
    .b_in   (b_in),
    .sel_in (sel_in),
    .cin    (cin),
    .ser_r  (ser_r),
    .ser_l  (ser_l),
    .f_out  (f_out),
    .cout   (cout)
);

// File: tb/sim_alsu_core.sv
`timescale 1ns/100ps
module sim_alsu_core;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [3:0]   sel_in = '0;
    logic         cin = 1'b0;
    logic         ser_r = 1'b0;
    logic         ser_l = 1'b0;
    logic [W-1:0] f_out;
    logic         cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alsu_core #(.WIDTH(W)) u0 (
        .a_in   (a_in),
        .b_in   (b_in),
        .sel_in (sel_in),
        .cin    (cin),
        .ser_r  (ser_r),
        .ser_l  (ser_l),
        .f_out  (f_out),
        .cout   (cout)
    );

    // Behavioural reference: returns {carry, result}.
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [3:0] s, input logic c,
                                         input logic sr, input logic sl);
        int unsigned ai = a;
        int unsigned bi = b;
        int unsigned yi;
        int unsigned tot;
        logic [W:0] r;
        r = '0;
        if (s[3:2] == 2'b00) begin
            if (s[1:0] == 2'b00)      yi = bi;
            else if (s[1:0] == 2'b01) yi = (2**W - 1) - bi;
            else if (s[1:0] == 2'b10) yi = 0;
            else                      yi = 2**W - 1;
            tot = ai + yi + (c ? 1 : 0);
            r = tot[W:0];
        end else if (s[3:2] == 2'b01) begin
            if (s[1:0] == 2'b00)      r[W-1:0] = a & b;
            else if (s[1:0] == 2'b01) r[W-1:0] = a | b;
            else if (s[1:0] == 2'b10) r[W-1:0] = a ^ b;
            else                      r[W-1:0] = ~a;
        end else if (s[3:2] == 2'b10) begin
            r[W-1:0] = (ai / 2) + (sr ? 2**(W-1) : 0);
        end else begin
            r[W-1:0] = ((ai * 2) % 2**W) + (sl ? 1 : 0);
        end
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] s);
        case (s[3:2])
            2'b00: case (s[1:0])
                2'b00: return "R1";
                2'b01: return "R2";
                2'b10: return "R3";
                default: return "R4";
            endcase
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(input logic [W:0] exp, input string req);
        checks++;
        if ({cout, f_out} !== exp) begin
            errors++;
            $display("FAIL %s: got cout=%0b f=%h expected cout=%0b f=%h",
                     req, cout, f_out, exp[W], exp[W-1:0]);
        end
    endtask

    // Drive half a nanosecond after a rising edge, check one nanosecond later,
    // before the falling edge: no clock edge lies between stimulus and check (R9).
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] s,
                         input logic c, input logic sr, input logic sl, input string req);
        @(posedge clk);
        #0.5;
        a_in = a; b_in = b; sel_in = s; cin = c; ser_r = sr; ser_l = sl;
        #1;
        compare(model(a, b, s, c, sr, sl), req);
    endtask

    task automatic expect_val(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] s,
                              input logic c, input logic sr, input logic sl,
                              input logic [W:0] exp, input string req);
        @(posedge clk);
        #0.5;
        a_in = a; b_in = b; sel_in = s; cin = c; ser_r = sr; ser_l = sl;
        #1;
        compare(exp, req);
    endtask

    initial begin
        #1.5;
        // Initial state: all-zero inputs give add of zeros
        compare(17'h0_0000, "R1");

        // R1 add and add with carry, hand-computed
        expect_val(16'h1234, 16'h1111, 4'b0000, 1'b0, 0, 0, 17'h0_2345, "R1");
        expect_val(16'h1234, 16'h1111, 4'b0000, 1'b1, 0, 0, 17'h0_2346, "R1");
        // R8 carry ripples through all stages
        expect_val(16'hFFFF, 16'h0000, 4'b0000, 1'b1, 0, 0, 17'h1_0000, "R8");
        expect_val(16'h8000, 16'h8000, 4'b0000, 1'b0, 0, 0, 17'h1_0000, "R8");
        // R2 subtract
        expect_val(16'h0005, 16'h0003, 4'b0001, 1'b1, 0, 0, 17'h1_0002, "R2");
        expect_val(16'h0003, 16'h0005, 4'b0001, 1'b1, 0, 0, 17'h0_FFFE, "R2");
        expect_val(16'h0005, 16'h0003, 4'b0001, 1'b0, 0, 0, 17'h1_0001, "R2");
        // R3 transfer / increment with wrap
        expect_val(16'hABCD, 16'h5555, 4'b0010, 1'b0, 0, 0, 17'h0_ABCD, "R3");
        expect_val(16'hFFFF, 16'h5555, 4'b0010, 1'b1, 0, 0, 17'h1_0000, "R3");
        // R4 decrement / transfer
        expect_val(16'h0000, 16'h1234, 4'b0011, 1'b0, 0, 0, 17'h0_FFFF, "R4");
        expect_val(16'h0010, 16'h1234, 4'b0011, 1'b0, 0, 0, 17'h1_000F, "R4");
        expect_val(16'h0000, 16'h1234, 4'b0011, 1'b1, 0, 0, 17'h1_0000, "R4");
        // R5 logic, cin toggled with no effect
        expect_val(16'hF0F0, 16'hFF00, 4'b0100, 1'b1, 0, 0, 17'h0_F000, "R5");
        expect_val(16'hF0F0, 16'hFF00, 4'b0101, 1'b1, 0, 0, 17'h0_FFF0, "R5");
        expect_val(16'hF0F0, 16'hFF00, 4'b0110, 1'b0, 0, 0, 17'h0_0FF0, "R5");
        expect_val(16'hF0F0, 16'hFF00, 4'b0110, 1'b1, 0, 0, 17'h0_0FF0, "R5");
        expect_val(16'hF0F0, 16'hFF00, 4'b0111, 1'b1, 0, 0, 17'h0_0F0F, "R5");
        // R6 shift right, ignored inputs varied
        expect_val(16'h8001, 16'h0000, 4'b1000, 1'b0, 1, 0, 17'h0_C000, "R6");
        expect_val(16'h8001, 16'hFFFF, 4'b1011, 1'b1, 1, 1, 17'h0_C000, "R6");
        expect_val(16'h8001, 16'hFFFF, 4'b1001, 1'b1, 0, 1, 17'h0_4000, "R6");
        // R7 shift left, ignored inputs varied
        expect_val(16'h8001, 16'h0000, 4'b1100, 1'b0, 0, 1, 17'h0_0003, "R7");
        expect_val(16'h8001, 16'hFFFF, 4'b1111, 1'b1, 1, 1, 17'h0_0003, "R7");
        expect_val(16'h8001, 16'hFFFF, 4'b1110, 1'b1, 1, 0, 17'h0_0002, "R7");

        // Random sweep against the model, one comparison per clock
        for (int n = 0; n < 600; n++) begin
            logic [3:0] s;
            s = 4'($urandom_range(0, 15));
            apply(16'($urandom), 16'($urandom), s, 1'($urandom), 1'($urandom),
                  1'($urandom), req_of(s));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule